// File: doc/BRIEF.md
# Paged Register Bank Steering Decoder

This block sits behind a byte-wide register bus and decides which of several register sets an access reaches. It has one shared set and four per-channel sets, each implementing sixteen byte registers. A page/channel select register at the top address chooses where accesses go. The steering covers the shared set, one chosen channel, or every channel at once for writes.

Software first writes the select register. It then reads and writes the low addresses, which land in whichever set the select value points at. A broadcast mode lets one write program the same register in all channels. Reads always return the contents of a single channel: the one named by the select value's channel field.

The select register is write-only. A read of its address returns zero.

Top module: `paged_reg_decoder`

## Requirements
- R1: After reset every register in every set, the select register and the read data output are all 0x00.
- R2: With select bit 2 (page enable) clear, reads and writes of addresses 0x00 to 0x0F reach the shared set only, and select bit 3 has no effect.
- R3: With select bit 2 set and bit 3 clear, a write to 0x00 to 0x0F updates only the channel named by select bits 1:0. No other channel and not the shared set is touched.
- R4: With select bits 2 and 3 both set, a write to 0x00 to 0x0F updates that address in all four channels and leaves the shared set unchanged.
- R5: With select bit 2 set, a read returns the register of the channel in select bits 1:0, whether select bit 3 is set or clear.
- R6: A write to address 0xFF always loads the select register, whatever the current page setting. It never writes any shared or channel register.
- R7: A read of address 0xFF returns 0x00.
- R8: Select bits 7:4 are not stored. A select write with nonzero upper bits steers exactly like the same write with those bits cleared.
- R9: Addresses 0x10 to 0xFE hold no register. Writes to them change nothing and reads of them return 0x00.
- R10: Read data is registered. It shows the addressed value from the cycle after the read strobe and holds until the next read strobe.
- R11: A write and a read of the same register in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |

## Verification
Several select patterns are used: shared page, each single channel in turn, broadcast with paging on, and broadcast with paging off. Each write is followed by reads of every set that it could have reached, so that a write landing in the wrong set shows up as a value where zero was expected. Select writes carrying junk upper bits are compared against their clean equivalents. Unimplemented addresses are probed so that aliasing onto the low registers is exposed. Simultaneous write and read of one register tells registered-old-value read behaviour apart from write-through.

// File: rtl/paged_reg_pkg.sv
package paged_reg_pkg;
   localparam int PRD_CH_W   = 2;
   localparam int PRD_NUM_CH = 1 << PRD_CH_W;
   localparam int PRD_SEL_W  = PRD_CH_W + 2;

   // Stored select fields; packed so that the channel field sits in the low bits,
   // page enable above it and broadcast at the top.
   typedef struct packed {
      logic                bcast;
      logic                page_en;
      logic [PRD_CH_W-1:0] ch;
   } prd_sel_t;
endpackage

// File: rtl/prd_page_select.sv
module prd_page_select
   import paged_reg_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [PRD_SEL_W-1:0] load_val,
   output prd_sel_t             sel
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         sel <= '0;
      else if (load)
         sel <= prd_sel_t'(load_val);
   end
endmodule

// File: rtl/prd_addr_steer.sv
module prd_addr_steer
   import paged_reg_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          DEPTH    = 16,
   parameter int          NUM_CH   = PRD_NUM_CH,
   parameter bit          BCAST_EN = 1'b1,
   parameter logic [ADDR_W-1:0] SEL_ADDR = '1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  prd_sel_t          sel,
   output logic              in_range,
   output logic              sel_we,
   output logic              shared_we,
   output logic [NUM_CH-1:0] ch_we
);
   assign in_range  = (32'(addr) < DEPTH);
   assign sel_we    = wr && (addr == SEL_ADDR);
   assign shared_we = wr && in_range && !sel.page_en;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      if (BCAST_EN) begin : g_bc
         assign ch_we[c] = wr && in_range && sel.page_en &&
                           (sel.bcast || (sel.ch == PRD_CH_W'(c)));
      end else begin : g_nobc
         assign ch_we[c] = wr && in_range && sel.page_en &&
                           (sel.ch == PRD_CH_W'(c));
      end
   end
endmodule

// File: rtl/prd_reg_bank.sv
module prd_reg_bank #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] regs_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) regs_q[i] <= '0;
      end else if (we) begin
         regs_q[idx] <= wdata;
      end
   end

   assign rdata = regs_q[idx];
endmodule

// File: rtl/prd_read_mux.sv
module prd_read_mux
   import paged_reg_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int NUM_CH = PRD_NUM_CH
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rd,
   input  logic                          in_range,
   input  prd_sel_t                      sel,
   input  logic [DATA_W-1:0]             shared_rdata,
   input  logic [NUM_CH-1:0][DATA_W-1:0] ch_rdata,
   output logic [DATA_W-1:0]             rdata
);
   logic [DATA_W-1:0] pick;

   always_comb begin
      if (!in_range)
         pick = '0;
      else if (sel.page_en)
         pick = ch_rdata[sel.ch];
      else
         pick = shared_rdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd)
         rdata <= pick;
   end
endmodule

// File: rtl/paged_reg_decoder.sv
module paged_reg_decoder
   import paged_reg_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 8,
   parameter int DEPTH    = 16,
   parameter int NUM_CH   = PRD_NUM_CH,
   parameter bit BCAST_EN = 1'b1,
   localparam int IDX_W   = $clog2(DEPTH),
   localparam logic [ADDR_W-1:0] SEL_ADDR = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata
);
   if (NUM_CH != PRD_NUM_CH) begin : g_bad_ch
      $error("NUM_CH must match the channel field width of the select register");
   end
   if (DATA_W < PRD_SEL_W) begin : g_bad_dw
      $error("DATA_W too narrow for the select fields");
   end
   if (DEPTH < 2 || DEPTH >= (1 << ADDR_W) - 1 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two below the select address");
   end

   prd_sel_t                      sel;
   logic                          in_range, sel_we, shared_we;
   logic [NUM_CH-1:0]             ch_we;
   logic [DATA_W-1:0]             shared_rdata;
   logic [NUM_CH-1:0][DATA_W-1:0] ch_rdata;
   logic [IDX_W-1:0]              idx;

   assign idx = bus_addr[IDX_W-1:0];

   prd_page_select u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sel_we),
      .load_val (bus_wdata[PRD_SEL_W-1:0]),
      .sel      (sel)
   );

   prd_addr_steer #(
      .ADDR_W   (ADDR_W),
      .DEPTH    (DEPTH),
      .NUM_CH   (NUM_CH),
      .BCAST_EN (BCAST_EN),
      .SEL_ADDR (SEL_ADDR)
   ) u_steer (
      .addr      (bus_addr),
      .wr        (bus_wr),
      .sel       (sel),
      .in_range  (in_range),
      .sel_we    (sel_we),
      .shared_we (shared_we),
      .ch_we     (ch_we)
   );

   prd_reg_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_shared (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (shared_we),
      .idx   (idx),
      .wdata (bus_wdata),
      .rdata (shared_rdata)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
      prd_reg_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ch (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (ch_we[c]),
         .idx   (idx),
         .wdata (bus_wdata),
         .rdata (ch_rdata[c])
      );
   end

   prd_read_mux #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_rmux (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd           (bus_rd),
      .in_range     (in_range),
      .sel          (sel),
      .shared_rdata (shared_rdata),
      .ch_rdata     (ch_rdata),
      .rdata        (bus_rdata)
   );
endmodule

// File: rtl/paged_reg_decoder_chk.sv
module paged_reg_decoder_chk
   import paged_reg_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int NUM_CH = PRD_NUM_CH
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input prd_sel_t          sel,
   input logic              shared_we,
   input logic [NUM_CH-1:0] ch_we
);
   localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

   AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == TOP_ADDR) |=> (PRD_SEL_W'(sel) == $past(bus_wdata[PRD_SEL_W-1:0]))); // R6
   AST_TOP_NO_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == TOP_ADDR) |-> (!shared_we && ch_we == '0)); // R6
   AST_TOP_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == TOP_ADDR) |=> (bus_rdata == '0)); // R7
   AST_HOLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && 32'(bus_addr) >= DEPTH) |=> (bus_rdata == '0)); // R9
   AST_HOLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(bus_addr) >= DEPTH) |-> (!shared_we && ch_we == '0)); // R9
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata)); // R10
   AST_PAGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(shared_we && (ch_we != '0))); // R2
   AST_SINGLE_CH: assert property (@(posedge clk) disable iff (!rst_n)
      !sel.bcast |-> $onehot0(ch_we)); // R3
   AST_BCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && 32'(bus_addr) < DEPTH && sel.page_en && sel.bcast) |-> (&ch_we)); // R4
endmodule

bind paged_reg_decoder paged_reg_decoder_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .DEPTH  (DEPTH),
   .NUM_CH (NUM_CH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .sel       (sel),
   .shared_we (shared_we),
   .ch_we     (ch_we)
);

// File: tb/paged_reg_decoder_bench.sv
`timescale 1ns/1ps
module paged_reg_decoder_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   paged_reg_decoder u_paged_reg_decoder (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic t_reset();
      check("R1 rdata after reset", bus_rdata, 8'h00);
      rd_chk("R1 shared reg", 8'h03, 8'h00);
      wr(8'hFF, 8'h06);
      rd_chk("R1 channel reg", 8'h03, 8'h00);
      wr(8'hFF, 8'h00);
   endtask

   task automatic t_shared();
      wr(8'hFF, 8'h00);
      wr(8'h03, 8'hA5);
      rd_chk("R2 shared readback", 8'h03, 8'hA5);
      wr(8'hFF, 8'h08);                      // broadcast bit with paging off
      wr(8'h08, 8'h77);
      rd_chk("R2 bcast bit ignored, shared", 8'h08, 8'h77);
      for (int c = 0; c < 4; c++) begin
         wr(8'hFF, 8'h04 | 8'(c));
         rd_chk("R2 channel untouched", 8'h03, 8'h00);
         rd_chk("R2 channel untouched by bcast-off", 8'h08, 8'h00);
      end
   endtask

   task automatic t_channel();
      for (int c = 0; c < 4; c++) begin
         wr(8'hFF, 8'h04 | 8'(c));
         wr(8'h05, 8'h10 + 8'(c));
      end
      for (int c = 0; c < 4; c++) begin
         wr(8'hFF, 8'h04 | 8'(c));
         rd_chk("R3 per-channel value", 8'h05, 8'h10 + 8'(c));
      end
      wr(8'hFF, 8'h00);
      rd_chk("R3 shared untouched", 8'h05, 8'h00);
   endtask

   task automatic t_bcast();
      wr(8'hFF, 8'h0D);
      wr(8'h07, 8'h3C);
      for (int c = 0; c < 4; c++) begin
         wr(8'hFF, 8'h04 | 8'(c));
         rd_chk("R4 broadcast reached channel", 8'h07, 8'h3C);
      end
      wr(8'hFF, 8'h00);
      rd_chk("R4 shared untouched", 8'h07, 8'h00);
   endtask

   task automatic t_read_route();
      wr(8'hFF, 8'h0E);
      rd_chk("R5 read from ch2 with bcast set", 8'h05, 8'h12);
      wr(8'hFF, 8'h0C);
      rd_chk("R5 read from ch0 with bcast set", 8'h05, 8'h10);
   endtask

   task automatic t_sel_write();
      wr(8'hFF, 8'h06);                      // page on, ch2
      wr(8'hFF, 8'h05);                      // must load despite paging on
      rd_chk("R6 select reloaded under paging", 8'h05, 8'h11);
      wr(8'hFF, 8'h00);
      rd_chk("R6 shared reg0 not hit by select write", 8'h00, 8'h00);
      wr(8'hFF, 8'h04);
      rd_chk("R6 ch0 reg0 not hit by select write", 8'h00, 8'h00);
   endtask

   task automatic t_sel_read();
      wr(8'hFF, 8'h07);
      rd_chk("R7 select read, paging on", 8'hFF, 8'h00);
      wr(8'hFF, 8'h00);
      rd_chk("R7 select read, paging off", 8'hFF, 8'h00);
   endtask

   task automatic t_upper_bits();
      wr(8'hFF, 8'hF7);
      rd_chk("R8 upper select bits ignored", 8'h05, 8'h13);
      wr(8'hFF, 8'hA0);
      rd_chk("R8 junk-only select acts as shared", 8'h03, 8'hA5);
   endtask

   task automatic t_holes();
      wr(8'hFF, 8'h00);
      wr(8'h10, 8'h66);
      wr(8'h23, 8'h99);
      rd_chk("R9 no alias onto reg0", 8'h00, 8'h00);
      rd_chk("R9 no alias onto reg3", 8'h03, 8'hA5);
      rd_chk("R9 hole reads zero", 8'h10, 8'h00);
      wr(8'hFF, 8'h0C);
      wr(8'hFE, 8'h55);
      wr(8'hFF, 8'h04);
      rd_chk("R9 channel reg14 untouched", 8'h0E, 8'h00);
      rd_chk("R9 hole reads zero, paged", 8'hFE, 8'h00);
   endtask

   task automatic t_read_timing();
      wr(8'hFF, 8'h00);
      @(negedge clk);
      bus_addr = 8'h08; bus_rd = 1'b1;
      #1 check("R10 no output before edge", bus_rdata, 8'h00);
      @(negedge clk);
      bus_rd = 1'b0;
      check("R10 data one cycle after strobe", bus_rdata, 8'h77);
      bus_addr = 8'h03;
      repeat (3) @(negedge clk);
      check("R10 data holds without strobe", bus_rdata, 8'h77);
   endtask

   task automatic t_same_cycle();
      wr(8'hFF, 8'h00);
      @(negedge clk);
      bus_addr = 8'h03; bus_wdata = 8'h5A; bus_wr = 1'b1; bus_rd = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      check("R11 same-cycle read returns old", bus_rdata, 8'hA5);
      rd_chk("R11 write landed", 8'h03, 8'h5A);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_shared();
      t_channel();
      t_bcast();
      t_read_route();
      t_sel_write();
      t_sel_read();
      t_upper_bits();
      t_holes();
      t_read_timing();
      t_same_cycle();
      finished = 1'b1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule